// File: doc/BRIEF.md
# Indexed Register Host Interface

This block is the host-facing register access unit of a network controller. The host sees only two byte-wide ports. A write to the index port stores an 8-bit register offset. Any following access to the data port then reads or writes the register that offset selects. Behind the pair sit five things: a network control register, a network status register, a read-only identification window, an interrupt status register and an interrupt mask register.

Hardware events set sticky flags in the status registers, and the host clears a flag by writing 1 to it. The interrupt status register also reports, in its top two bits, the host bus width strapped at power-up. A registered interrupt line asserts whenever an enabled status flag is pending. A software reset, requested through the control register, returns the registers to their defaults and clears itself.

Top module: `idx_reg_host`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata` as the current index, and a read with `bus_sel`=0 returns it. While `bus_sel`=1, reads and writes act on the register selected by the current index. The index keeps its value until the next index-port write, and a software reset does not change it.
- R2: Offsets 0x28, 0x29, 0x2A and 0x2B read the bytes of `CHIP_ID` (default 0x90000A46) from least to most significant, giving 0x46, 0x0A, 0x00, 0x90. Offset 0x2C reads `REV_ID` (default 0x19). Writes to these offsets change nothing.
- R3: Bits 7:6 of the interrupt status register (offset 0xFE) return `bus_strap` as sampled while `rst` was high. The codes are 0 for 16-bit, 1 for 32-bit and 2 for 8-bit. Later changes of `bus_strap`, writes to these bits and software resets leave them unchanged.
- R4: Status bits 3:0 at offset 0xFE are sticky. Bit 0 is receive done and bit 1 is transmit done; each bit k is set by a high `irq_evt[k]` at a clock edge. A data write clears every bit whose write-data bit is 1, so writing 0x0F clears all four. An event arriving in the same cycle as a clear wins. Bits 5:4 read 0.
- R5: The interrupt mask register (offset 0xFF) stores and reads back all 8 bits. Bit 7 drives `rx_wrap_en`, which enables automatic wrap of the receive-buffer read pointer.
- R6: `irq` is registered. It is 1 in the cycle after any clock edge at which (status[3:0] AND mask[3:0]) is non-zero, and 0 otherwise.
- R7: A data write to offset 0x00 with bit 0 set starts a software reset one edge later. At that next edge the control, network status flags, status bits 3:0, mask and `irq` return to 0. The reset request then clears itself, and bit 0 always reads 0.
- R8: The network status register (offset 0x01) shows `link_up` live in bit 6. Bits 2, 3 and 5 are sticky transmit-status flags set by `tx_evt[0]`, `tx_evt[1]` and `tx_evt[2]`. Writing 1 to a flag clears it, and an event in the same cycle wins. The other bits read 0.
- R9: Reads of any offset not named in R2 to R8 return 0x00, and writes to them have no effect on any register or output.
- R10: Offset 0x00 stores bits 7:1 of a data write and reads them back. They also appear on `net_ctrl`, which keeps bit 0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Port select: 0 index port, 1 data port |
| bus_we | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the selected port |
| bus_strap | input | 2 | Strapped host bus width code |
| irq_evt | input | 4 | Interrupt status event pulses, bit k sets status bit k |
| tx_evt | input | 3 | Transmit-status event pulses for network status bits 2, 3, 5 |
| link_up | input | 1 | Live link state |
| irq | output | 1 | Registered interrupt request |
| rx_wrap_en | output | 1 | Mask bit 7, receive pointer auto-wrap enable |
| net_ctrl | output | 8 | Stored control register value |

## Verification
Corrupted internal state shows up at the ports quickly. A wrong index or a broken decode returns the wrong byte on the very next data-port read. A lost or doubled interrupt flag shows on `irq` exactly one edge after the status and mask line up. A software reset that fails to clear a register, or that clears the strap bits, shows on the first read after the second edge following the control write. Each such effect appears within one or two cycles of its cause.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int DW       = 8;
    localparam int IRQ_BITS = 4;
    localparam int TXS_BITS = 3;

    localparam logic [DW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [DW-1:0] OFS_NSTAT = 8'h01;
    localparam logic [DW-1:0] OFS_ID0   = 8'h28;
    localparam logic [DW-1:0] OFS_ID3   = 8'h2B;
    localparam logic [DW-1:0] OFS_REV   = 8'h2C;
    localparam logic [DW-1:0] OFS_ISTAT = 8'hFE;
    localparam logic [DW-1:0] OFS_IMASK = 8'hFF;

    localparam int LINK_POS = 6;

    typedef enum logic [1:0] {
        BUS_W16  = 2'd0,
        BUS_W32  = 2'd1,
        BUS_W8   = 2'd2,
        BUS_RSVD = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic ctrl;
        logic nstat;
        logic istat;
        logic imask;
    } wr_sel_t;

    function automatic int txs_pos(input int k);
        case (k)
            0:       return 2;
            1:       return 3;
            default: return 5;
        endcase
    endfunction

    function automatic logic [DW-1:0] id_byte(input logic [31:0] id, input logic [1:0] k);
        return id[k*8 +: 8];
    endfunction

endpackage

// File: rtl/hreg_index.sv
module hreg_index
    import hreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] idx,
    output wr_sel_t       wsel
);

    logic data_wr;

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (bus_we && !bus_sel)
            idx <= bus_wdata;
    end

    assign data_wr = bus_we && bus_sel;

    always_comb begin
        wsel       = '0;
        wsel.ctrl  = data_wr && (idx == OFS_CTRL);
        wsel.nstat = data_wr && (idx == OFS_NSTAT);
        wsel.istat = data_wr && (idx == OFS_ISTAT);
        wsel.imask = data_wr && (idx == OFS_IMASK);
    end

    // R1: the index only moves on an index-port write
    p_idx_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && !bus_sel) |=> $stable(idx));

endmodule

// File: rtl/hreg_ctrl.sv
module hreg_ctrl
    import hreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_ctrl,
    input  logic                wr_nstat,
    input  logic [DW-1:0]       wdata,
    input  logic [TXS_BITS-1:0] tx_evt,
    input  logic                link_up,
    output logic                srst,
    output logic [DW-1:0]       ctrl_q,
    output logic [DW-1:0]       nstat_rd
);

    logic [TXS_BITS-1:0] txs_q;
    logic                clr_all;

    assign clr_all = rst || srst;

    always_ff @(posedge clk) begin
        if (rst)
            srst <= 1'b0;
        else
            srst <= !srst && wr_ctrl && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (clr_all)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= {wdata[DW-1:1], 1'b0};
    end

    for (genvar k = 0; k < TXS_BITS; k++) begin : g_txs
        localparam int POS = txs_pos(k);
        always_ff @(posedge clk) begin
            if (clr_all)
                txs_q[k] <= 1'b0;
            else
                txs_q[k] <= tx_evt[k] || (txs_q[k] && !(wr_nstat && wdata[POS]));
        end
    end

    always_comb begin
        nstat_rd           = '0;
        nstat_rd[LINK_POS] = link_up;
        for (int k = 0; k < TXS_BITS; k++)
            nstat_rd[txs_pos(k)] = txs_q[k];
    end

    // R7: the reset request lasts exactly one cycle
    p_srst_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        srst |=> !srst);

    // R7: the software reset empties the control register
    p_srst_clears_r7: assert property (@(posedge clk) disable iff (rst)
        srst |=> (ctrl_q == '0));

    // R8: a transmit event is never lost to a same-cycle clear
    p_txs_set_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_evt[0] && !srst) |=> txs_q[0]);

endmodule

// File: rtl/hreg_intr.sv
module hreg_intr
    import hreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                srst,
    input  logic                wr_istat,
    input  logic                wr_imask,
    input  logic [DW-1:0]       wdata,
    input  logic [1:0]          bus_strap,
    input  logic [IRQ_BITS-1:0] irq_evt,
    output logic [DW-1:0]       istat_rd,
    output logic [DW-1:0]       imask_q,
    output logic                irq
);

    bus_mode_e           strap_q;
    logic [IRQ_BITS-1:0] flag_q;
    logic                clr_all;

    assign clr_all = rst || srst;

    always_ff @(posedge clk) begin
        if (rst)
            strap_q <= bus_mode_e'(bus_strap);
    end

    for (genvar k = 0; k < IRQ_BITS; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (clr_all)
                flag_q[k] <= 1'b0;
            else
                flag_q[k] <= irq_evt[k] || (flag_q[k] && !(wr_istat && wdata[k]));
        end
    end

    always_ff @(posedge clk) begin
        if (clr_all)
            imask_q <= '0;
        else if (wr_imask)
            imask_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (clr_all)
            irq <= 1'b0;
        else
            irq <= |(flag_q & imask_q[IRQ_BITS-1:0]);
    end

    always_comb begin
        istat_rd                   = '0;
        istat_rd[DW-1 -: 2]        = strap_q;
        istat_rd[IRQ_BITS-1:0]     = flag_q;
    end

    // R3: the strap copy survives software resets
    p_strap_hold_r3: assert property (@(posedge clk) disable iff (rst)
        srst |=> $stable(strap_q));

    // R4: a receive event always leaves its flag set
    p_evt_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_evt[0] && !srst) |=> flag_q[0]);

    // R6: a pending enabled flag raises irq one edge later
    p_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (!srst && |(flag_q & imask_q[IRQ_BITS-1:0])) |=> irq);

    // R6: no enabled flag means no irq one edge later
    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !(|(flag_q & imask_q[IRQ_BITS-1:0])) |=> !irq);

endmodule

// File: rtl/idx_reg_host.sv
module idx_reg_host
    import hreg_pkg::*;
#(
    parameter logic [31:0] CHIP_ID = 32'h90000A46,
    parameter logic [7:0]  REV_ID  = 8'h19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [1:0]          bus_strap,
    input  logic [IRQ_BITS-1:0] irq_evt,
    input  logic [TXS_BITS-1:0] tx_evt,
    input  logic                link_up,
    output logic                irq,
    output logic                rx_wrap_en,
    output logic [DW-1:0]       net_ctrl
);

    logic [DW-1:0] idx;
    wr_sel_t       wsel;
    logic          srst;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] nstat_rd;
    logic [DW-1:0] istat_rd;
    logic [DW-1:0] imask_q;
    logic [DW-1:0] data_rd;

    hreg_index u_index (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .idx       (idx),
        .wsel      (wsel)
    );

    hreg_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wsel.ctrl),
        .wr_nstat (wsel.nstat),
        .wdata    (bus_wdata),
        .tx_evt   (tx_evt),
        .link_up  (link_up),
        .srst     (srst),
        .ctrl_q   (ctrl_q),
        .nstat_rd (nstat_rd)
    );

    hreg_intr u_intr (
        .clk       (clk),
        .rst       (rst),
        .srst      (srst),
        .wr_istat  (wsel.istat),
        .wr_imask  (wsel.imask),
        .wdata     (bus_wdata),
        .bus_strap (bus_strap),
        .irq_evt   (irq_evt),
        .istat_rd  (istat_rd),
        .imask_q   (imask_q),
        .irq       (irq)
    );

    always_comb begin
        data_rd = '0;
        if (idx >= OFS_ID0 && idx <= OFS_ID3)
            data_rd = id_byte(CHIP_ID, idx[1:0]);
        else begin
            case (idx)
                OFS_CTRL:  data_rd = ctrl_q;
                OFS_NSTAT: data_rd = nstat_rd;
                OFS_REV:   data_rd = REV_ID;
                OFS_ISTAT: data_rd = istat_rd;
                OFS_IMASK: data_rd = imask_q;
                default:   data_rd = '0;
            endcase
        end
    end

    assign bus_rdata  = bus_sel ? data_rd : idx;
    assign rx_wrap_en = imask_q[DW-1];
    assign net_ctrl   = ctrl_q;

    // R10: bit 0 of the control output is never seen high
    p_ctrl_bit0_r10: assert property (@(posedge clk) disable iff (rst)
        !net_ctrl[0]);

endmodule

// File: tb/idx_reg_host_bench.sv
module idx_reg_host_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] bus_strap = 2'd2;
    logic [3:0] irq_evt = 4'h0;
    logic [2:0] tx_evt = 3'h0;
    logic       link_up = 1'b0;
    logic       irq;
    logic       rx_wrap_en;
    logic [7:0] net_ctrl;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    idx_reg_host u_idx_reg_host (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_strap  (bus_strap),
        .irq_evt    (irq_evt),
        .tx_evt     (tx_evt),
        .link_up    (link_up),
        .irq        (irq),
        .rx_wrap_en (rx_wrap_en),
        .net_ctrl   (net_ctrl)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] ofs, input logic [7:0] d);
        wr_port(1'b0, ofs);
        wr_port(1'b1, d);
    endtask

    task automatic rd_reg(input logic [7:0] ofs, output logic [7:0] d);
        wr_port(1'b0, ofs);
        @(negedge clk);
        bus_sel = 1'b1; #1;
        d = bus_rdata;
    endtask

    task automatic pulse_evt(input logic [3:0] ie, input logic [2:0] te);
        @(negedge clk);
        irq_evt = ie; tx_evt = te;
        @(posedge clk); #1;
        irq_evt = 4'h0; tx_evt = 3'h0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R6 reset irq", {7'd0, irq}, 8'h00);
        check("R10 reset ctrl", net_ctrl, 8'h00);
        rd_reg(8'hFE, v); check("R3 strap 8-bit", v, 8'h80);
        bus_strap = 2'd1;
        rd_reg(8'hFE, v); check("R3 strap held", v, 8'h80);
    endtask

    task automatic t_index;
        logic [7:0] v;
        wr_port(1'b0, 8'h5A);
        @(negedge clk); bus_sel = 1'b0; #1;
        check("R1 index readback", bus_rdata, 8'h5A);
    endtask

    task automatic t_id;
        logic [7:0] v;
        rd_reg(8'h28, v); check("R2 id0", v, 8'h46);
        rd_reg(8'h29, v); check("R2 id1", v, 8'h0A);
        rd_reg(8'h2A, v); check("R2 id2", v, 8'h00);
        rd_reg(8'h2B, v); check("R2 id3", v, 8'h90);
        rd_reg(8'h2C, v); check("R2 rev", v, 8'h19);
        wr_reg(8'h28, 8'hFF);
        rd_reg(8'h28, v); check("R2 id write ignored", v, 8'h46);
    endtask

    task automatic t_istat;
        logic [7:0] v;
        pulse_evt(4'h3, 3'h0);
        rd_reg(8'hFE, v); check("R4 set rx+tx", v, 8'h83);
        wr_reg(8'hFE, 8'h01);
        rd_reg(8'hFE, v); check("R4 w1c bit0", v, 8'h82);
        pulse_evt(4'hC, 3'h0);
        wr_reg(8'hFE, 8'hFF);
        rd_reg(8'hFE, v); check("R4 clear all, strap kept R3", v, 8'h80);
        // event in the same cycle as its clear
        wr_port(1'b0, 8'hFE);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 8'h02; irq_evt = 4'h2;
        @(posedge clk); #1;
        bus_we = 1'b0; irq_evt = 4'h0;
        rd_reg(8'hFE, v); check("R4 set wins", v, 8'h82);
        wr_reg(8'hFE, 8'h0F);
    endtask

    task automatic t_imask_irq;
        logic [7:0] v;
        wr_reg(8'hFF, 8'h81);
        rd_reg(8'hFF, v); check("R5 mask readback", v, 8'h81);
        check("R5 wrap enable", {7'd0, rx_wrap_en}, 8'h01);
        pulse_evt(4'h2, 3'h0);
        check("R6 masked source", {7'd0, irq}, 8'h00);
        @(negedge clk);
        irq_evt = 4'h1;
        @(posedge clk); #1;
        irq_evt = 4'h0;
        check("R6 not yet", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        check("R6 asserted", {7'd0, irq}, 8'h01);
        wr_reg(8'hFE, 8'h01);
        check("R6 still high", {7'd0, irq}, 8'h01);
        @(posedge clk); #1;
        check("R6 dropped", {7'd0, irq}, 8'h00);
        wr_reg(8'hFE, 8'h0F);
    endtask

    task automatic t_nstat;
        logic [7:0] v;
        link_up = 1'b1;
        rd_reg(8'h01, v); check("R8 link", v, 8'h40);
        pulse_evt(4'h0, 3'h7);
        rd_reg(8'h01, v); check("R8 sticky", v, 8'h6C);
        wr_reg(8'h01, 8'h04);
        rd_reg(8'h01, v); check("R8 clear bit2", v, 8'h68);
        wr_reg(8'h01, 8'h2C);
        rd_reg(8'h01, v); check("R8 clear all", v, 8'h40);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        wr_reg(8'h30, 8'h55);
        rd_reg(8'h30, v); check("R9 unmapped read", v, 8'h00);
        check("R9 ctrl untouched", net_ctrl, 8'h00);
        rd_reg(8'hFF, v); check("R9 mask untouched", v, 8'h81);
    endtask

    task automatic t_ctrl_srst;
        logic [7:0] v;
        wr_reg(8'h00, 8'h06);
        check("R10 ctrl out", net_ctrl, 8'h06);
        rd_reg(8'h00, v); check("R10 ctrl read", v, 8'h06);
        pulse_evt(4'h1, 3'h1);
        wr_reg(8'h00, 8'h07);
        check("R7 bit0 reads 0", net_ctrl, 8'h06);
        @(posedge clk); #1;
        check("R7 ctrl cleared", net_ctrl, 8'h00);
        check("R7 wrap cleared", {7'd0, rx_wrap_en}, 8'h00);
        @(negedge clk); bus_sel = 1'b0; #1;
        check("R7 index kept", bus_rdata, 8'h00);
        rd_reg(8'hFE, v); check("R7 istat cleared, strap kept", v, 8'h80);
        rd_reg(8'hFF, v); check("R7 mask cleared", v, 8'h00);
        rd_reg(8'h01, v); check("R7 nstat cleared", v, 8'h40);
        check("R7 irq cleared", {7'd0, irq}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset();
        t_index();
        t_id();
        t_istat();
        t_imask_irq();
        t_nstat();
        t_unmapped();
        t_ctrl_srst();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule